// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block owns the device's internal active-low reset from the moment power appears until normal operation begins. It waits for two supply-good indications. It then turns on a slow oscillator and counts a selectable number of slow-oscillator periods. After that it releases the internal reset, hands clocking over to the fast oscillator and strobes the start of the downstream initialization. Analog threshold detection and the oscillators are outside the block: each supply monitor appears as a digital level. Each slow-oscillator period appears as a one-cycle `slow_tick` strobe. The block logic runs on a single reference clock `clk`.

An asynchronous active-low external reset pad forces the internal reset at once and floats the user I/Os. Its release is resynchronized, and it returns the device to operation without rerunning the power-up delay. A second active-low reset for user logic follows the internal reset. It is also held low for a fixed number of cycles after a programming-complete or zeroization-complete event. Losing either supply at any moment returns the block to its power-up state.

Top module: `por_sequencer`

## Requirements
- R1: While `vdd_good` or `vpp_good` is low, `sys_rst_n` and `user_rst_n` are low and both `slow_osc_en` and `fast_osc_en` are low.
- R2: Once both supplies are good, `slow_osc_en` goes high and stays high while the delay is being counted, one count per `slow_tick`.
- R3: `dly_sel` values 0, 1, 2 and 3 pick delays of DLY_T0, DLY_T1, DLY_T2 and DLY_T3 ticks (defaults 50, 1000, 10000, 100000). `sys_rst_n` rises on the clock edge that samples the last of those ticks.
- R4: On the edge that releases `sys_rst_n`, `slow_osc_en` falls and `fast_osc_en` rises. The two enables are never high together.
- R5: `init_start` is a one-cycle pulse in the cycle after `sys_rst_n` is released.
- R6: `ext_rst_n` low drives `sys_rst_n` and `user_rst_n` low asynchronously, without waiting for a clock edge, and leaves the oscillator enables unchanged.
- R7: After `ext_rst_n` returns high, `sys_rst_n` rises on the second `clk` edge. No slow oscillator is enabled and no delay is counted. `init_start` pulses for one cycle on the third edge.
- R8: `io_hiz` is high, asynchronously, while `ext_rst_n` is low. It returns low on the same edge on which `sys_rst_n` returns high.
- R9: A one-cycle `prog_done` or `zero_done` pulse holds `user_rst_n` low for exactly HOLD_CYC (default 16) cycles, starting at the edge that samples it. `sys_rst_n` and the oscillator enables are unaffected.
- R10: Losing either supply at any time immediately reasserts both resets, disables both oscillators and clears the delay count. The next power-up counts the full delay again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all sequencing logic |
| vdd_good | input | 1 | Core supply above threshold |
| vpp_good | input | 1 | Auxiliary supply above threshold |
| dly_sel | input | 2 | Power-up delay selection, captured when counting starts |
| ext_rst_n | input | 1 | Asynchronous active-low external reset pad |
| slow_tick | input | 1 | One-cycle strobe per slow-oscillator period |
| prog_done | input | 1 | Programming-complete event pulse |
| zero_done | input | 1 | Zeroization-complete event pulse |
| sys_rst_n | output | 1 | Internal active-low reset |
| user_rst_n | output | 1 | Active-low reset for user logic |
| slow_osc_en | output | 1 | Slow oscillator enable |
| fast_osc_en | output | 1 | Fast oscillator enable |
| io_hiz | output | 1 | Tri-state all user I/Os when high |
| init_start | output | 1 | One-cycle strobe starting initialization |

## Verification
The bench builds the block with delays of 4, 7, 11 and 15 ticks and the default 16-cycle user hold. It supplies a slow tick every third clock while the slow enable is high. The short delays let every delay selection run to release in a few dozen cycles, and the bench counts the ticks it handed out. They also make a supply loss partway through a count, followed by a full recount, cheap to reach. The real 16-cycle hold keeps the exact pulse-length check meaningful.

// File: rtl/por_pkg.sv
package por_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_START = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/por_pad_sync.sv
module por_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic ok
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign ok = sh_q[STAGES-1];

endmodule

// File: rtl/por_delay_ctrl.sv
module por_delay_ctrl #(
    parameter int DLY_T0 = 50,
    parameter int DLY_T1 = 1000,
    parameter int DLY_T2 = 10000,
    parameter int DLY_T3 = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] dly_sel,
    input  logic       slow_tick,
    input  logic       ext_ok,
    output logic       run,
    output logic       slow_en,
    output logic       fast_en,
    output logic       init
);
    import por_pkg::*;

    localparam int MAX_A = (DLY_T0 > DLY_T1) ? DLY_T0 : DLY_T1;
    localparam int MAX_B = (DLY_T2 > DLY_T3) ? DLY_T2 : DLY_T3;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] ONE = 1;
    localparam logic [3:0][CNT_W-1:0] LIMS = {
        CNT_W'(DLY_T3), CNT_W'(DLY_T2), CNT_W'(DLY_T1), CNT_W'(DLY_T0)
    };

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       sel;
        logic             run;
        logic             slow_en;
        logic             fast_en;
        logic             init;
        logic             ext_prev;
    } regs_t;

    localparam regs_t RESET_V = '{
        state: ST_OFF, cnt: '0, sel: 2'd0, run: 1'b0,
        slow_en: 1'b0, fast_en: 1'b0, init: 1'b0, ext_prev: 1'b0
    };

    regs_t r_d, r_q;
    logic [CNT_W-1:0] lim;

    assign lim = LIMS[r_q.sel];

    always_comb begin
        r_d          = r_q;
        r_d.init     = 1'b0;
        r_d.ext_prev = ext_ok;
        unique case (r_q.state)
            ST_OFF: begin
                // Supplies are good whenever this register is out of reset.
                r_d.cnt     = '0;
                r_d.sel     = dly_sel;
                r_d.slow_en = 1'b1;
                r_d.state   = ST_COUNT;
            end
            ST_COUNT: begin
                if (slow_tick) begin
                    if (r_q.cnt == lim - ONE) begin
                        r_d.cnt     = '0;
                        r_d.run     = 1'b1;
                        r_d.slow_en = 1'b0;
                        r_d.fast_en = 1'b1;
                        r_d.state   = ST_START;
                    end else begin
                        r_d.cnt = r_q.cnt + ONE;
                    end
                end
            end
            ST_START: begin
                r_d.init  = 1'b1;
                r_d.state = ST_RUN;
            end
            ST_RUN: begin
                // Pad reset released: restart initialization, no delay.
                if (ext_ok && !r_q.ext_prev) r_d.init = 1'b1;
            end
            default: r_d = RESET_V;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_V;
        else        r_q <= r_d;
    end

    assign run     = r_q.run;
    assign slow_en = r_q.slow_en;
    assign fast_en = r_q.fast_en;
    assign init    = r_q.init;

    p_osc_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.slow_en && r_q.fast_en))
        else $error("both oscillators enabled");

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < lim)
        else $error("delay count beyond terminal value");

    p_init_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.run) |=> r_q.init)
        else $error("no init strobe after release");

    p_no_rerun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.run |=> (!r_q.slow_en && r_q.run))
        else $error("delay restarted without supply loss");

    p_slow_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_COUNT) |-> r_q.slow_en)
        else $error("counting without slow oscillator");

endmodule

// File: rtl/por_user_hold.sv
module por_user_hold #(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_done,
    input  logic zero_done,
    output logic hold
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] ONE  = 1;
    localparam logic [HW-1:0] LOAD = HW'(HOLD_CYC);

    typedef struct packed {
        logic [HW-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;
    logic  evt;

    assign evt = prog_done | zero_done;

    always_comb begin
        r_d = r_q;
        if (evt)                r_d.cnt = LOAD;
        else if (r_q.cnt != '0) r_d.cnt = r_q.cnt - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hold = (r_q.cnt != '0);

    p_hold_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cnt != '0 && !evt) |=> (r_q.cnt == $past(r_q.cnt) - ONE))
        else $error("hold counter skipped a step");

endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
    parameter int DLY_T0   = 50,
    parameter int DLY_T1   = 1000,
    parameter int DLY_T2   = 10000,
    parameter int DLY_T3   = 100000,
    parameter int HOLD_CYC = 16
) (
    input  logic       clk,
    input  logic       vdd_good,
    input  logic       vpp_good,
    input  logic [1:0] dly_sel,
    input  logic       ext_rst_n,
    input  logic       slow_tick,
    input  logic       prog_done,
    input  logic       zero_done,
    output logic       sys_rst_n,
    output logic       user_rst_n,
    output logic       slow_osc_en,
    output logic       fast_osc_en,
    output logic       io_hiz,
    output logic       init_start
);

    logic pwr_ok;
    logic pad_clr_n;
    logic ext_ok;
    logic run;
    logic hold;

    assign pwr_ok    = vdd_good & vpp_good;
    assign pad_clr_n = ext_rst_n & pwr_ok;

    por_pad_sync #(.STAGES(2)) u_pad_sync (
        .clk   (clk),
        .clr_n (pad_clr_n),
        .ok    (ext_ok)
    );

    por_delay_ctrl #(
        .DLY_T0 (DLY_T0),
        .DLY_T1 (DLY_T1),
        .DLY_T2 (DLY_T2),
        .DLY_T3 (DLY_T3)
    ) u_delay (
        .clk       (clk),
        .rst_n     (pwr_ok),
        .dly_sel   (dly_sel),
        .slow_tick (slow_tick),
        .ext_ok    (ext_ok),
        .run       (run),
        .slow_en   (slow_osc_en),
        .fast_en   (fast_osc_en),
        .init      (init_start)
    );

    por_user_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk       (clk),
        .rst_n     (pwr_ok),
        .prog_done (prog_done),
        .zero_done (zero_done),
        .hold      (hold)
    );

    assign sys_rst_n  = run & ext_ok;
    assign user_rst_n = sys_rst_n & ~hold;
    assign io_hiz     = ~ext_ok;

    p_usr_under_sys_r6: assert property (@(posedge clk) disable iff (!pwr_ok)
        !sys_rst_n |-> !user_rst_n)
        else $error("user reset released before internal reset");

    p_hiz_pad_r8: assert property (@(posedge clk) disable iff (!pwr_ok)
        !ext_rst_n |-> (io_hiz && !sys_rst_n))
        else $error("pad low without tri-state");

endmodule

// File: tb/por_sequencer_bench.sv
module por_sequencer_bench;

    localparam int T0 = 4, T1 = 7, T2 = 11, T3 = 15, HOLD = 16;

    logic       clk = 1'b0;
    logic       vdd_good = 1'b1, vpp_good = 1'b1;
    logic [1:0] dly_sel = 2'd0;
    logic       ext_rst_n = 1'b1;
    logic       slow_tick = 1'b0;
    logic       prog_done = 1'b0, zero_done = 1'b0;
    logic       sys_rst_n, user_rst_n, slow_osc_en, fast_osc_en, io_hiz, init_start;

    int errors = 0;
    int checks = 0;
    int ticks_seen = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    por_sequencer #(
        .DLY_T0(T0), .DLY_T1(T1), .DLY_T2(T2), .DLY_T3(T3), .HOLD_CYC(HOLD)
    ) u_por_sequencer (
        .clk(clk), .vdd_good(vdd_good), .vpp_good(vpp_good), .dly_sel(dly_sel),
        .ext_rst_n(ext_rst_n), .slow_tick(slow_tick), .prog_done(prog_done),
        .zero_done(zero_done), .sys_rst_n(sys_rst_n), .user_rst_n(user_rst_n),
        .slow_osc_en(slow_osc_en), .fast_osc_en(fast_osc_en), .io_hiz(io_hiz),
        .init_start(init_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Slow oscillator model: one tick every third clock while enabled.
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            if (slow_osc_en === 1'b1) begin
                div++;
                if (div == 3) begin
                    div = 0;
                    slow_tick = 1'b1;
                    ticks_seen++;
                end else begin
                    slow_tick = 1'b0;
                end
            end else begin
                div = 0;
                slow_tick = 1'b0;
            end
        end
    end

    task automatic power_up(input logic [1:0] sel, input int lim, input string tag);
        bit saw_slow = 1'b0;
        int n = 0;
        @(negedge clk);
        ticks_seen = 0;
        dly_sel  = sel;
        vdd_good = 1'b1;
        vpp_good = 1'b1;
        while (sys_rst_n !== 1'b1 && n < 2000) begin
            @(negedge clk);
            if (slow_osc_en === 1'b1) saw_slow = 1'b1;
            n++;
        end
        chk({tag, " R2 slow osc during count"}, saw_slow, 1);
        chk({tag, " R3 ticks to release"}, ticks_seen, lim);
        chk({tag, " R4 slow off at release"}, slow_osc_en, 0);
        chk({tag, " R4 fast on at release"}, fast_osc_en, 1);
        chk({tag, " R5 no strobe at release"}, init_start, 0);
        @(negedge clk);
        chk({tag, " R5 strobe next cycle"}, init_start, 1);
        @(negedge clk);
        chk({tag, " R5 strobe one cycle"}, init_start, 0);
        chk({tag, " R2 user reset released"}, user_rst_n, 1);
    endtask

    task automatic power_down(input string tag);
        @(negedge clk);
        vdd_good = 1'b0;
        #1;
        chk({tag, " R10 sys reset"}, sys_rst_n, 0);
        chk({tag, " R10 user reset"}, user_rst_n, 0);
        chk({tag, " R10 fast off"}, fast_osc_en, 0);
        chk({tag, " R10 slow off"}, slow_osc_en, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset_state();
        vdd_good = 1'b0;
        vpp_good = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 sys low", sys_rst_n, 0);
        chk("R1 user low", user_rst_n, 0);
        chk("R1 slow off", slow_osc_en, 0);
        chk("R1 fast off", fast_osc_en, 0);
        vdd_good = 1'b1;
        repeat (30) @(negedge clk);
        chk("R1 one supply: slow off", slow_osc_en, 0);
        chk("R1 one supply: sys low", sys_rst_n, 0);
        vdd_good = 1'b0;
        vpp_good = 1'b1;
        repeat (30) @(negedge clk);
        chk("R1 other supply: slow off", slow_osc_en, 0);
        vpp_good = 1'b0;
    endtask

    task automatic test_pad();
        bit saw_slow = 1'b0;
        @(negedge clk);
        ticks_seen = 0;
        ext_rst_n = 1'b0;
        #1;
        chk("R6 pad: sys low at once", sys_rst_n, 0);
        chk("R6 pad: user low at once", user_rst_n, 0);
        chk("R8 pad: hiz at once", io_hiz, 1);
        chk("R6 pad: fast kept", fast_osc_en, 1);
        repeat (10) begin
            @(negedge clk);
            if (slow_osc_en === 1'b1) saw_slow = 1'b1;
        end
        chk("R8 pad: hiz held", io_hiz, 1);
        ext_rst_n = 1'b1;
        @(negedge clk);
        chk("R7 release: low after edge 1", sys_rst_n, 0);
        chk("R8 release: hiz after edge 1", io_hiz, 1);
        @(negedge clk);
        chk("R7 release: high after edge 2", sys_rst_n, 1);
        chk("R8 release: hiz cleared", io_hiz, 0);
        chk("R7 release: no strobe yet", init_start, 0);
        @(negedge clk);
        chk("R7 release: strobe edge 3", init_start, 1);
        if (slow_osc_en === 1'b1) saw_slow = 1'b1;
        @(negedge clk);
        chk("R7 release: strobe one cycle", init_start, 0);
        chk("R7 no slow osc", saw_slow, 0);
        chk("R7 no ticks counted", ticks_seen, 0);
    endtask

    task automatic test_hold(input bit zero, input string tag);
        int n = 0;
        bit sys_drop = 1'b0;
        bit fast_drop = 1'b0;
        @(negedge clk);
        chk({tag, " R9 user high before"}, user_rst_n, 1);
        if (zero) zero_done = 1'b1;
        else      prog_done = 1'b1;
        @(negedge clk);
        prog_done = 1'b0;
        zero_done = 1'b0;
        while (user_rst_n === 1'b0 && n < 100) begin
            if (sys_rst_n !== 1'b1) sys_drop = 1'b1;
            if (fast_osc_en !== 1'b1) fast_drop = 1'b1;
            n++;
            @(negedge clk);
        end
        chk({tag, " R9 hold length"}, n, HOLD);
        chk({tag, " R9 sys untouched"}, sys_drop, 0);
        chk({tag, " R9 fast untouched"}, fast_drop, 0);
    endtask

    task automatic test_midcount_loss();
        @(negedge clk);
        ticks_seen = 0;
        dly_sel  = 2'd3;
        vdd_good = 1'b1;
        vpp_good = 1'b1;
        while (ticks_seen < 5) @(negedge clk);
        vpp_good = 1'b0;
        #1;
        chk("R10 mid-count slow off", slow_osc_en, 0);
        chk("R10 mid-count sys low", sys_rst_n, 0);
        repeat (4) @(negedge clk);
        power_up(2'd3, T3, "recount");
    endtask

    initial begin
        #2;
        test_reset_state();
        power_up(2'd0, T0, "sel0");
        power_down("after sel0");
        power_up(2'd1, T1, "sel1");
        power_down("after sel1");
        power_up(2'd2, T2, "sel2");
        power_down("after sel2");
        power_up(2'd3, T3, "sel3");
        test_pad();
        test_hold(1'b0, "prog");
        test_hold(1'b1, "zero");
        power_down("in run");
        test_midcount_loss();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule